// File: doc/BRIEF.md
# All-Transitions Test Vector Sequencer

This block produces, one per enabled clock cycle, a walk over all 2^W vectors of a W-bit bus in which every ordered pair of distinct vectors appears exactly once as two consecutive outputs. The walk is the shortest possible for this property: 2^W × (2^W − 1) + 1 vectors. It begins and ends on the all-zeros vector, and no vector ever follows itself.

The walk is computed on the fly from two node counters and a small phase machine, with no stored table. From a home node `a` it steps out to each higher node `b` below the top node and back to `a`. It then visits the all-ones node and moves on to home node `a+1`. After the last home node it closes on zero. A driver feeds the outputs to a circuit under test so that every bit-transition pattern of its inputs is exercised. `en` paces the walk, `valid_o` marks each fresh vector and `last_o` flags the closing one. A synchronous `restart` pulse or reset rewinds the walk to its start.

Top module: `vecwalk_seq`

## Requirements
- R1: After reset or a restart pulse, `valid_o` and `last_o` are low, and the first vector emitted afterwards is all zeros.
- R2: A cycle with `en` high and `restart` low, before the walk is finished, produces one vector with `valid_o` high in the following cycle. A cycle with `en` low gives `valid_o` low in the following cycle, and `vec_o` keeps its value.
- R3: Two consecutive emitted vectors are never equal.
- R4: Every ordered pair (x, y) of distinct W-bit values occurs exactly once as consecutive emitted vectors x then y.
- R5: The walk holds exactly 2^W × (2^W − 1) + 1 emitted vectors, for example 57 for W = 3 and 65281 for W = 8.
- R6: `last_o` is high, together with `valid_o`, only on the final vector of the walk, and that vector is all zeros.
- R7: The order follows the rule above. For W = 2 it is exactly 0, 1, 0, 2, 0, 3, 1, 2, 1, 3, 2, 3, 0 (values as unsigned integers of `vec_o`).
- R8: After the final vector, further enabled cycles leave `valid_o` and `last_o` low until a restart or reset.
- R9: `restart` acts at the next clock edge and takes priority over `en`. The cycle after it shows `valid_o` low, and the walk then begins again from its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous pulse that rewinds the walk |
| en | input | 1 | Advance the walk by one vector this cycle |
| vec_o | output | W | Current test vector |
| valid_o | output | 1 | A new vector is on `vec_o` this cycle |
| last_o | output | 1 | `vec_o` is the final vector of the walk |

## Verification
The bench builds the block twice, once with W = 3 and once with W = 2, and drives both from the same enable and restart stimulus. With W = 3 the whole 57-vector walk fits in a 64-entry pair table, so pair coverage, duplicate pairs, repeats and total length are all checked exhaustively. The W = 2 instance is compared vector by vector against the fixed 13-step order. Idle enable gaps, enables after the walk has finished, and a restart raised together with `en` partway through the walk cover the pacing and rewind corners.

// File: rtl/vecwalk_pkg.sv
package vecwalk_pkg;

    // Phase of the walk: what the next enabled cycle will emit.
    typedef enum logic [2:0] {
        PH_BEGIN = 3'd0,  // opening all-zeros vector
        PH_HOME  = 3'd1,  // arrival at a new home node a
        PH_AWAY  = 3'd2,  // excursion to node b
        PH_BACK  = 3'd3,  // return from b to a
        PH_TOP   = 3'd4,  // visit to the all-ones node
        PH_CLOSE = 3'd5,  // closing all-zeros vector
        PH_DONE  = 3'd6   // walk finished, nothing to emit
    } phase_e;

endpackage

// File: rtl/vecwalk_step.sv
// Pure combinational successor function of the walk.
module vecwalk_step
    import vecwalk_pkg::*;
#(
    parameter int W = 3
) (
    input  phase_e         ph_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output phase_e         ph_o,
    output logic [W-1:0]   a_o,
    output logic [W-1:0]   b_o,
    output logic [W-1:0]   vec_o,
    output logic           emit_o,
    output logic           fin_o
);
    localparam int NODES = 1 << W;
    localparam logic [W-1:0] TOP_NODE = W'(NODES - 1);
    localparam logic [W-1:0] LOW_MAX  = W'(NODES - 2);

    logic [W-1:0] a_inc;
    logic [W-1:0] b_inc;

    assign a_inc = a_i + W'(1);
    assign b_inc = b_i + W'(1);

    always_comb begin
        ph_o   = ph_i;
        a_o    = a_i;
        b_o    = b_i;
        vec_o  = '0;
        emit_o = 1'b1;
        fin_o  = 1'b0;
        unique case (ph_i)
            PH_BEGIN, PH_HOME: begin
                vec_o = (ph_i == PH_BEGIN) ? '0 : a_i;
                if (ph_i == PH_BEGIN) begin
                    a_o = '0;
                end
                if (((ph_i == PH_BEGIN) ? {W{1'b0}} : a_i) != LOW_MAX) begin
                    ph_o = PH_AWAY;
                    b_o  = (ph_i == PH_BEGIN) ? W'(1) : a_inc;
                end else begin
                    ph_o = PH_TOP;
                end
            end
            PH_AWAY: begin
                vec_o = b_i;
                ph_o  = PH_BACK;
            end
            PH_BACK: begin
                vec_o = a_i;
                if (b_i != LOW_MAX) begin
                    b_o  = b_inc;
                    ph_o = PH_AWAY;
                end else begin
                    ph_o = PH_TOP;
                end
            end
            PH_TOP: begin
                vec_o = TOP_NODE;
                if (a_i != LOW_MAX) begin
                    a_o  = a_inc;
                    ph_o = PH_HOME;
                end else begin
                    ph_o = PH_CLOSE;
                end
            end
            PH_CLOSE: begin
                vec_o = '0;
                fin_o = 1'b1;
                ph_o  = PH_DONE;
            end
            default: begin
                emit_o = 1'b0;
                ph_o   = PH_DONE;
            end
        endcase
    end

endmodule

// File: rtl/vecwalk_outreg.sv
// Output stage: holds the vector, pulses valid and last.
module vecwalk_outreg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] vec_d,
    input  logic         last_d,
    output logic [W-1:0] vec_q,
    output logic         valid_q,
    output logic         last_q
);
    typedef struct packed {
        logic [W-1:0] vec;
        logic         valid;
        logic         last;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = 1'b0;
        o_d.last  = 1'b0;
        if (!clr && load) begin
            o_d.vec   = vec_d;
            o_d.valid = 1'b1;
            o_d.last  = last_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign vec_q   = o_q.vec;
    assign valid_q = o_q.valid;
    assign last_q  = o_q.last;

    assert_valid_needs_load_R2: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(load) && !$past(clr));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(vec_q));

endmodule

// File: rtl/vecwalk_seq.sv
module vecwalk_seq
    import vecwalk_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         en,
    output logic [W-1:0] vec_o,
    output logic         valid_o,
    output logic         last_o
);
    typedef struct packed {
        phase_e       ph;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } walk_t;

    walk_t        st_d, st_q;
    phase_e       nx_ph;
    logic [W-1:0] nx_a;
    logic [W-1:0] nx_b;
    logic [W-1:0] nx_vec;
    logic         nx_emit;
    logic         nx_fin;

    vecwalk_step #(.W(W)) step_i (
        .ph_i   (st_q.ph),
        .a_i    (st_q.a),
        .b_i    (st_q.b),
        .ph_o   (nx_ph),
        .a_o    (nx_a),
        .b_o    (nx_b),
        .vec_o  (nx_vec),
        .emit_o (nx_emit),
        .fin_o  (nx_fin)
    );

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '{ph: PH_BEGIN, a: '0, b: '0};
        end else if (en) begin
            st_d = '{ph: nx_ph, a: nx_a, b: nx_b};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_BEGIN, a: '0, b: '0};
        end else begin
            st_q <= st_d;
        end
    end

    vecwalk_outreg #(.W(W)) out_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (restart),
        .load    (en && nx_emit),
        .vec_d   (nx_vec),
        .last_d  (nx_fin),
        .vec_q   (vec_o),
        .valid_q (valid_o),
        .last_q  (last_o)
    );

    // Tracking of the previous emitted vector, used only by the assertions.
    logic [W-1:0] prev_q;
    logic         seen_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else if (valid_o) begin
            prev_q <= vec_o;
            seen_q <= 1'b1;
        end
    end

    assert_first_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !seen_q) |-> (vec_o == '0));

    assert_no_repeat_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && seen_q) |-> (vec_o != prev_q));

    assert_last_zero_R6: assert property (@(posedge clk) disable iff (rst)
        last_o |-> (valid_o && vec_o == '0));

    assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !valid_o);

    assert_restart_idle_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!valid_o && !last_o));

endmodule

// File: tb/vecwalk_seq_tb_top.sv
module vecwalk_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN3 = 8 * 7 + 1;
    localparam int LEN2 = 4 * 3 + 1;

    logic clk = 1'b0;
    logic rst, restart, en;
    logic [2:0] vec3;
    logic [1:0] vec2;
    logic valid3, last3, valid2, last2;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vecwalk_seq #(.W(3)) dut_i (
        .clk(clk), .rst(rst), .restart(restart), .en(en),
        .vec_o(vec3), .valid_o(valid3), .last_o(last3)
    );

    vecwalk_seq #(.W(2)) dut_w2_i (
        .clk(clk), .rst(rst), .restart(restart), .en(en),
        .vec_o(vec2), .valid_o(valid2), .last_o(last2)
    );

    int exp2 [LEN2] = '{0, 1, 0, 2, 0, 3, 1, 2, 1, 3, 2, 3, 0};

    logic seen [64];
    int   cnt3, idx2;
    logic have3, done3;
    logic [2:0] prev3;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic e, input logic r);
        en = e;
        restart = r;
        @(negedge clk);
    endtask

    task automatic clear_track();
        for (int i = 0; i < 64; i++) seen[i] = 1'b0;
        cnt3 = 0; idx2 = 0; have3 = 1'b0; done3 = 1'b0; prev3 = '0;
    endtask

    task automatic observe();
        if (valid3) begin
            cnt3++;
            if (cnt3 == 1) chk(vec3 == 3'd0, "R1 first vector", int'(vec3), 0);
            if (have3) begin
                chk(vec3 != prev3, "R3 repeat", int'(vec3), int'(prev3) + 1);
                chk(!seen[{prev3, vec3}], "R4 duplicate pair", int'({prev3, vec3}), -1);
                seen[{prev3, vec3}] = 1'b1;
            end
            if (last3) begin
                done3 = 1'b1;
                chk(vec3 == 3'd0, "R6 last vector", int'(vec3), 0);
                chk(cnt3 == LEN3, "R5 length", cnt3, LEN3);
            end
            prev3 = vec3;
            have3 = 1'b1;
        end else begin
            chk(!last3, "R6 last without valid", int'(last3), 0);
        end
        if (valid2) begin
            if (idx2 < LEN2) chk(int'(vec2) == exp2[idx2], "R7 order W2", int'(vec2), exp2[idx2]);
            else chk(1'b0, "R7 extra W2 vector", idx2, LEN2 - 1);
            if (last2) chk(idx2 == LEN2 - 1, "R6 last W2 position", idx2, LEN2 - 1);
            idx2++;
        end
    endtask

    task automatic check_pairs();
        int missing = 0;
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++)
                if (x != y && !seen[x * 8 + y]) missing++;
        chk(missing == 0, "R4 missing pairs", missing, 0);
        chk(idx2 == LEN2, "R7 W2 count", idx2, LEN2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; restart = 1'b0; en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!valid3 && !last3, "R1 reset outputs", int'({valid3, last3}), 0);
        chk(!valid2 && !last2, "R1 reset outputs W2", int'({valid2, last2}), 0);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        chk(!valid3, "R2 idle after reset", int'(valid3), 0);

        // Pass 1: full walk with periodic idle cycles.
        clear_track();
        for (int i = 0; i < 400 && !done3; i++) begin
            logic e;
            logic [2:0] held;
            e = (i % 7 != 6);
            held = vec3;
            tick(e, 1'b0);
            if (!e) begin
                chk(!valid3, "R2 valid without en", int'(valid3), 0);
                chk(vec3 == held, "R2 vector held", int'(vec3), int'(held));
            end else begin
                chk(valid3, "R2 valid after en", int'(valid3), 1);
            end
            observe();
        end
        chk(done3, "R5 walk completed", int'(done3), 1);
        check_pairs();

        // Enables after the end.
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, 1'b0);
            chk(!valid3 && !last3, "R8 idle after last", int'({valid3, last3}), 0);
            chk(!valid2 && !last2, "R8 idle after last W2", int'({valid2, last2}), 0);
        end

        // Restart, partial walk, restart together with en, full walk.
        tick(1'b1, 1'b1);
        chk(!valid3 && !last3, "R9 restart idle", int'({valid3, last3}), 0);
        clear_track();
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, 1'b0);
            observe();
        end
        chk(cnt3 == 10, "R2 partial count", cnt3, 10);
        tick(1'b1, 1'b1);
        chk(!valid3, "R9 restart beats en", int'(valid3), 0);
        chk(!valid2, "R9 restart beats en W2", int'(valid2), 0);
        clear_track();
        for (int i = 0; i < 200 && !done3; i++) begin
            tick(1'b1, 1'b0);
            observe();
        end
        chk(done3, "R9 walk completed after restart", int'(done3), 1);
        check_pairs();
        tick(1'b1, 1'b0);
        chk(!valid3, "R8 idle after second walk", int'(valid3), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule